// File: doc/BRIEF.md
# Panel Power and Backlight Sequencer

This block orders the supplies and enables of a flat-panel display module. A single panel-on request starts the turn-on: the logic supply is enabled first, the video outputs and both backlight rails (high-voltage rail and inverter standby supply) follow as soon as the logic supply reports power-good, and the backlight on/off control comes up only after a minimum settling period. Dropping the request runs the order in reverse: the backlight control drops first, the video outputs and the rails follow after a gap, and the logic supply is removed last.

Every delay is counted in pulses of a free-running millisecond tick input, and every delay is a parameter. The block enforces a maximum rise window on the logic supply and enters a latched fault state, with every enable off, if power-good does not come within it. After each removal of the logic supply a minimum off-time runs before another turn-on may begin; a request arriving during that window waits. A request withdrawn part-way through turn-on reverses the order from the step reached. All outputs come straight from flops.

Top module: `panel_pwr_seq`

## Requirements
- R1: Reset leaves every enable and the backlight control low, `ready` and `fault` low and `busy` high; the block then counts T_OFF_MIN ticks of off-time before it can start, after which it rests idle with `busy` low.
- R2: A request while idle raises `logic_en` alone, with `busy` high; the other enables stay low until power-good.
- R3: Once `logic_pgood` is seen during the logic step, `video_en`, `bl_rail_en` and `inv_stby_en` rise together on the next clock; `video_en` is never high while `logic_en` is low.
- R4: If T_PGOOD_MAX ticks pass in the logic step without power-good, all enables drop and `fault` rises and stays high while the request stays high; dropping the request leaves the fault and starts the off-time.
- R5: `bl_on` rises after max(T_LOGIC_TO_BL, T_VIDEO_TO_BL) ticks counted from the rise of `video_en`, and not after fewer; `ready` rises with it, and `bl_on` is high only while `video_en`, `bl_rail_en` and `inv_stby_en` are high.
- R6: Dropping the request while on drops `bl_on` and `ready` at once; video and both rails stay on for T_BLOFF_TO_VIDEO ticks and then drop together; `logic_en` drops exactly one clock after them; a request raised again in this phase does not stop the turn-off.
- R7: After `logic_en` falls, it cannot rise again until T_OFF_MIN ticks have been counted; a request held through the window starts the turn-on once the window ends.
- R8: Dropping the request during the logic step drops `logic_en` on the next clock; dropping it during the settling step (video on, backlight control off) drops video and rails at once and `logic_en` one clock later.
- R9: `ready` is high only in the fully-on state; `busy` is high in every timed or transitional step and low when idle, fully on or faulted; `fault` is high only in the fault state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| panel_on_req | input | 1 | High requests the panel on, low requests it off |
| logic_pgood | input | 1 | Power-good from the logic supply |
| logic_en | output | 1 | Logic supply enable |
| video_en | output | 1 | Video signal output enable |
| bl_rail_en | output | 1 | Backlight high-voltage rail enable |
| inv_stby_en | output | 1 | Inverter standby supply enable |
| bl_on | output | 1 | Backlight on/off control |
| ready | output | 1 | Panel fully on |
| busy | output | 1 | A timed or transitional step is in progress |
| fault | output | 1 | Logic supply failed to come up in time |

## Verification
The bench sweeps the arrival of power-good across every tick of the rise window, including the tick on which the window closes; a design with an off-by-one limit would either fault a good supply or start video on a late one. For every delay it checks that nothing moves after one tick fewer than the limit and that the step changes after exactly the limit, so a counter that includes the entry tick or forgets the larger of the two backlight gaps shows up at once. Requests withdrawn in the logic step, in the settling step and re-raised during turn-off are driven, and a monitor times the gap between the fall of video and the fall of the logic supply; a design that removed the logic supply first, skipped the off-time or resumed turn-on from the middle of turn-off would break these checks.

// File: rtl/pseq_pkg.sv
`timescale 1ns/1ps
package pseq_pkg;

   typedef enum logic [2:0] {
      ST_HOLD  = 3'd0,
      ST_IDLE  = 3'd1,
      ST_LOGIC = 3'd2,
      ST_VIDEO = 3'd3,
      ST_ON    = 3'd4,
      ST_BLDN  = 3'd5,
      ST_VIDDN = 3'd6,
      ST_FAULT = 3'd7
   } pseq_state_e;

   localparam int OUT_W   = 8;
   localparam int O_LOGIC = 7;
   localparam int O_VIDEO = 6;
   localparam int O_RAIL  = 5;
   localparam int O_STBY  = 4;
   localparam int O_BL    = 3;
   localparam int O_READY = 2;
   localparam int O_BUSY  = 1;
   localparam int O_FAULT = 0;

   function automatic logic [OUT_W-1:0] out_decode(pseq_state_e s);
      logic [OUT_W-1:0] o;
      o = '0;
      o[O_LOGIC] = (s == ST_LOGIC) || (s == ST_VIDEO) || (s == ST_ON) ||
                   (s == ST_BLDN)  || (s == ST_VIDDN);
      o[O_VIDEO] = (s == ST_VIDEO) || (s == ST_ON) || (s == ST_BLDN);
      o[O_RAIL]  = o[O_VIDEO];
      o[O_STBY]  = o[O_VIDEO];
      o[O_BL]    = (s == ST_ON);
      o[O_READY] = (s == ST_ON);
      o[O_BUSY]  = (s == ST_HOLD) || (s == ST_LOGIC) || (s == ST_VIDEO) ||
                   (s == ST_BLDN) || (s == ST_VIDDN);
      o[O_FAULT] = (s == ST_FAULT);
      return o;
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pseq_tick_timer.sv
`timescale 1ns/1ps
module pseq_tick_timer #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);

   logic inc_ok;

   generate
      if (SATURATE) begin : g_sat
         assign inc_ok = tick && (cnt != {CNT_W{1'b1}});
      end else begin : g_wrap
         assign inc_ok = tick;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (inc_ok) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pseq_ctrl.sv
`timescale 1ns/1ps
module pseq_ctrl
   import pseq_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter logic [CNT_W-1:0] LIM_PGOOD = '0,
   parameter logic [CNT_W-1:0] LIM_BLWAIT = '0,
   parameter logic [CNT_W-1:0] LIM_BLOFF = '0,
   parameter logic [CNT_W-1:0] LIM_OFF = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             pgood,
   input  logic [CNT_W-1:0] cnt,
   output pseq_state_e      state,
   output pseq_state_e      state_nx,
   output logic             step_chg
);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_HOLD:  if (cnt >= LIM_OFF) state_nx = ST_IDLE;
         ST_IDLE:  if (req) state_nx = ST_LOGIC;
         ST_LOGIC: begin
            if (!req)                  state_nx = ST_HOLD;
            else if (pgood)            state_nx = ST_VIDEO;
            else if (cnt >= LIM_PGOOD) state_nx = ST_FAULT;
         end
         ST_VIDEO: begin
            if (!req)                   state_nx = ST_VIDDN;
            else if (cnt >= LIM_BLWAIT) state_nx = ST_ON;
         end
         ST_ON:    if (!req) state_nx = ST_BLDN;
         ST_BLDN:  if (cnt >= LIM_BLOFF) state_nx = ST_VIDDN;
         ST_VIDDN: state_nx = ST_HOLD;
         ST_FAULT: if (!req) state_nx = ST_HOLD;
         default:  state_nx = ST_HOLD;
      endcase
   end

   assign step_chg = (state_nx != state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_HOLD;
      else        state <= state_nx;
   end

   // R4
   pgood_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOGIC && state_nx == ST_FAULT) |-> !pgood);

   // R6
   bldn_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BLDN && req) |=> (state == ST_BLDN || state == ST_VIDDN));

endmodule

// File: rtl/pseq_out_regs.sv
`timescale 1ns/1ps
module pseq_out_regs
   import pseq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  pseq_state_e      state_nx,
   output logic [OUT_W-1:0] outs
);

   localparam logic [OUT_W-1:0] RST_VAL = out_decode(ST_HOLD);

   logic [OUT_W-1:0] dec;
   assign dec = out_decode(state_nx);

   genvar gi;
   generate
      for (gi = 0; gi < OUT_W; gi++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) outs[gi] <= RST_VAL[gi];
            else        outs[gi] <= dec[gi];
         end
      end
   endgenerate

   // R3
   vid_needs_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      outs[O_VIDEO] |-> outs[O_LOGIC]);

   // R5
   bl_needs_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      outs[O_BL] |-> (outs[O_RAIL] && outs[O_STBY] && outs[O_VIDEO]));

endmodule

// File: rtl/panel_pwr_seq.sv
`timescale 1ns/1ps
module panel_pwr_seq
   import pseq_pkg::*;
#(
   parameter int T_PGOOD_MAX      = 10,
   parameter int T_LOGIC_TO_BL    = 180,
   parameter int T_VIDEO_TO_BL    = 100,
   parameter int T_BLOFF_TO_VIDEO = 20,
   parameter int T_OFF_MIN        = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic panel_on_req,
   input  logic logic_pgood,
   output logic logic_en,
   output logic video_en,
   output logic bl_rail_en,
   output logic inv_stby_en,
   output logic bl_on,
   output logic ready,
   output logic busy,
   output logic fault
);

   localparam int T_BL_WAIT = imax(T_LOGIC_TO_BL, T_VIDEO_TO_BL);
   localparam int T_MAX     = imax(imax(T_PGOOD_MAX, T_BL_WAIT),
                                   imax(T_BLOFF_TO_VIDEO, T_OFF_MIN));
   localparam int CNT_W     = $clog2(T_MAX + 1);

   localparam logic [CNT_W-1:0] LIM_PGOOD  = CNT_W'(T_PGOOD_MAX);
   localparam logic [CNT_W-1:0] LIM_BLWAIT = CNT_W'(T_BL_WAIT);
   localparam logic [CNT_W-1:0] LIM_BLOFF  = CNT_W'(T_BLOFF_TO_VIDEO);
   localparam logic [CNT_W-1:0] LIM_OFF    = CNT_W'(T_OFF_MIN);

   generate
      if (T_PGOOD_MAX < 1) begin : g_bad_pgood
         $error("T_PGOOD_MAX must be at least 1");
      end
      if (T_LOGIC_TO_BL < 0 || T_VIDEO_TO_BL < 0 ||
          T_BLOFF_TO_VIDEO < 0 || T_OFF_MIN < 0) begin : g_bad_delay
         $error("delays must not be negative");
      end
   endgenerate

   pseq_state_e      state, state_nx;
   logic             step_chg;
   logic [CNT_W-1:0] cnt;
   logic [OUT_W-1:0] outs;

   pseq_tick_timer #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (step_chg),
      .tick  (ms_tick),
      .cnt   (cnt)
   );

   pseq_ctrl #(
      .CNT_W      (CNT_W),
      .LIM_PGOOD  (LIM_PGOOD),
      .LIM_BLWAIT (LIM_BLWAIT),
      .LIM_BLOFF  (LIM_BLOFF),
      .LIM_OFF    (LIM_OFF)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (panel_on_req),
      .pgood    (logic_pgood),
      .cnt      (cnt),
      .state    (state),
      .state_nx (state_nx),
      .step_chg (step_chg)
   );

   pseq_out_regs u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_nx (state_nx),
      .outs     (outs)
   );

   assign logic_en    = outs[O_LOGIC];
   assign video_en    = outs[O_VIDEO];
   assign bl_rail_en  = outs[O_RAIL];
   assign inv_stby_en = outs[O_STBY];
   assign bl_on       = outs[O_BL];
   assign ready       = outs[O_READY];
   assign busy        = outs[O_BUSY];
   assign fault       = outs[O_FAULT];

   // R5
   bl_after_video_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bl_on) |-> $past(video_en));

   // R6
   rails_after_bl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bl_rail_en) |-> !$past(bl_on));

   // R6
   logic_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(logic_en) |-> (!video_en && !$past(video_en)));

   // R4
   fault_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!logic_en && !video_en && !bl_rail_en && !inv_stby_en && !bl_on));

endmodule

// File: tb/panel_pwr_seq_tb.sv
`timescale 1ns/1ps
module panel_pwr_seq_tb;

   localparam int PG   = 3;
   localparam int L2B  = 6;
   localparam int V2B  = 4;
   localparam int BOFF = 2;
   localparam int OFFM = 5;
   localparam int WAIT = (L2B > V2B) ? L2B : V2B;

   // bit order: logic video rail stby bl ready busy fault
   localparam logic [7:0] P_HOLD  = 8'b0000_0010;
   localparam logic [7:0] P_IDLE  = 8'b0000_0000;
   localparam logic [7:0] P_LOGIC = 8'b1000_0010;
   localparam logic [7:0] P_VIDEO = 8'b1111_0010;
   localparam logic [7:0] P_ON    = 8'b1111_1100;
   localparam logic [7:0] P_BLDN  = 8'b1111_0010;
   localparam logic [7:0] P_FAULT = 8'b0000_0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0;
   logic panel_on_req = 1'b0;
   logic logic_pgood = 1'b0;
   logic logic_en, video_en, bl_rail_en, inv_stby_en, bl_on, ready, busy, fault;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   panel_pwr_seq #(
      .T_PGOOD_MAX(PG), .T_LOGIC_TO_BL(L2B), .T_VIDEO_TO_BL(V2B),
      .T_BLOFF_TO_VIDEO(BOFF), .T_OFF_MIN(OFFM)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
      .panel_on_req(panel_on_req), .logic_pgood(logic_pgood),
      .logic_en(logic_en), .video_en(video_en), .bl_rail_en(bl_rail_en),
      .inv_stby_en(inv_stby_en), .bl_on(bl_on), .ready(ready),
      .busy(busy), .fault(fault)
   );

   function automatic logic [7:0] outs();
      return {logic_en, video_en, bl_rail_en, inv_stby_en, bl_on, ready, busy, fault};
   endfunction

   task automatic chk(string req, logic [7:0] exp);
      n_chk++;
      if (outs() !== exp) begin
         n_fail++;
         $display("FAIL %s: outputs %b expected %b at %0t", req, outs(), exp, $time);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic one_tick();
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      settle();
   endtask

   // ticks n-1 times checking pattern p_wait, then once more checking p_done
   task automatic tick_to(string req, int n, logic [7:0] p_wait, logic [7:0] p_done);
      for (int i = 1; i < n; i++) begin
         one_tick();
         chk(req, p_wait);
      end
      one_tick();
      chk(req, p_done);
   endtask

   // monitor: logic_en falls exactly one clock after video_en (R6, R8)
   int cyc = 0;
   int vfall = 0;
   bit pv = 1'b0, pl = 1'b0, vid_seen = 1'b0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (video_en) vid_seen = 1'b1;
         if (pv && !video_en) vfall = cyc;
         if (pl && !logic_en && vid_seen) begin
            n_chk++;
            if (cyc != vfall + 1) begin
               n_fail++;
               $display("FAIL R6: logic_en fell %0d cycles after video_en, expected 1",
                        cyc - vfall);
            end
         end
         if (!logic_en) vid_seen = 1'b0;
      end
      pv = video_en;
      pl = logic_en;
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual not done expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", P_HOLD);
      rst_n = 1'b1;
      settle();
      chk("R1 after reset", P_HOLD);
      tick_to("R1 off-time then idle", OFFM, P_HOLD, P_IDLE);
      chk("R9 idle not busy", P_IDLE);

      panel_on_req = 1'b1;
      settle();
      chk("R2 request raises logic only", P_LOGIC);

      // sweep power-good arrival over the whole rise window
      for (int k = 0; k <= PG; k++) begin
         if (k < PG) begin
            for (int i = 0; i < k; i++) begin
               one_tick();
               chk("R3 waiting for pgood", P_LOGIC);
            end
            logic_pgood = 1'b1;
            settle();
            chk("R3 pgood enables video and rails", P_VIDEO);
            tick_to("R5 backlight gap", WAIT, P_VIDEO, P_ON);
            chk("R9 ready when on", P_ON);
            if (k == 1) begin
               panel_on_req = 1'b0;
               settle();
               chk("R6 backlight drops first", P_BLDN);
               panel_on_req = 1'b1;
               settle();
               chk("R6 re-request ignored in turn-off", P_BLDN);
               tick_to("R6 video gap", BOFF, P_BLDN, P_HOLD);
            end else begin
               panel_on_req = 1'b0;
               settle();
               chk("R6 backlight drops first", P_BLDN);
               tick_to("R6 video gap", BOFF, P_BLDN, P_HOLD);
               panel_on_req = 1'b1;
            end
            logic_pgood = 1'b0;
            tick_to("R7 off-time before re-power", OFFM, P_HOLD, P_LOGIC);
         end else begin
            tick_to("R4 pgood timeout", PG, P_LOGIC, P_FAULT);
            one_tick();
            chk("R4 fault latched", P_FAULT);
            logic_pgood = 1'b1;
            settle();
            chk("R4 late pgood ignored", P_FAULT);
            logic_pgood = 1'b0;
            panel_on_req = 1'b0;
            settle();
            chk("R4 fault cleared by request drop", P_HOLD);
            panel_on_req = 1'b1;
            tick_to("R7 off-time after fault", OFFM, P_HOLD, P_LOGIC);
         end
      end

      // abort in the logic step
      one_tick();
      chk("R8 logic step before abort", P_LOGIC);
      panel_on_req = 1'b0;
      settle();
      chk("R8 abort in logic step", P_HOLD);
      panel_on_req = 1'b1;
      tick_to("R7 off-time after abort", OFFM, P_HOLD, P_LOGIC);

      // abort in the settling step
      logic_pgood = 1'b1;
      settle();
      chk("R8 settling step", P_VIDEO);
      tick_to("R8 settling before abort", WAIT - 1, P_VIDEO, P_VIDEO);
      panel_on_req = 1'b0;
      logic_pgood = 1'b0;
      settle();
      chk("R8 abort in settling step", P_HOLD);
      tick_to("R1 back to idle", OFFM, P_HOLD, P_IDLE);

      done = 1'b1;
      finish_run();
   end

endmodule